// File: doc/BRIEF.md
# Floating-Point Issue Hazard Checker

This block decides, in the decode stage of an in-order pipeline, whether the instruction being decoded may issue. The pipeline has an integer path with one execute stage, a fully pipelined FP adder with four stages, a fully pipelined FP multiplier with seven stages and a divider that is not pipelined and stays occupied for 25 cycles. The block keeps a valid bit and a destination tag for every one of these stages and for the single memory and write-back slots behind them. From that state it finds three kinds of hazard for the decoding instruction: a busy divider, a source that is not yet produced, and a destination that an older instruction in flight will still write. Any of these, or a write-port conflict reported by external logic, holds the instruction in decode. Once an instruction issues it is never held again.

One cycle after an instruction issues, the block drives a forwarding select for each of its two sources. The select says which pipeline register feeds the operand mux: one of the four registers in front of the memory stage, one for each kind of producer, or the register in front of write-back. Register specifiers are six bits wide: the top bit picks the register file and the low five bits give the index.

Top module: `fp_issue_guard`

## Requirements
- R1: With `dec_valid` high and no hazard, `dec_issue` is 1 and `dec_stall` is 0 in the same cycle. `dec_stall` always equals `dec_valid` and not `dec_issue`. With `dec_valid` low, both are 0. The adder and multiplier accept one operation every cycle.
- R2: A divide (unit code 4) stalls while the divider has more than one cycle of work left. A second divide can therefore issue 25 cycles after the first, in the last cycle the first one spends in the divider.
- R3: An instruction that writes a register stalls while any valid adder stage, multiplier stage or the divider holds an older instruction that writes the same register.
- R4: A source stalls issue when it names a register written by an instruction that is in a non-final adder or multiplier stage, in the divider with more than one cycle left, or is a load (unit code 1) in the integer execute stage. A producer in its final execute stage, in memory or in write-back causes no stall.
- R5: A high `wport_conflict` together with `dec_valid` forces a stall.
- R6: In the cycle after an issue, each source's select is: 1 if the instruction in the memory stage came from the integer path and writes that source, 2 if it came from the adder, 3 from the multiplier, 4 from the divider (loads excluded), 5 if the instruction in write-back writes it, otherwise 0. The select is 0 for an unused source and in any cycle that does not follow an issue.
- R7: When the memory-stage and write-back instructions both write the same source, the memory-stage one, which is the younger, sets the select.
- R8: Bit 5 of a specifier picks the file (1 = FP) and bits 4:0 give the index. A match needs both parts equal, so an integer register never has a hazard against the FP register with the same index.
- R9: Reset clears all tracked state. After reset, an instruction of any unit issues at once and both selects read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | An instruction is in decode |
| dec_unit | input | 3 | Unit: 0 integer, 1 load, 2 FP add, 3 FP multiply, 4 FP divide |
| dec_dst | input | 6 | Destination specifier |
| dec_dst_wr | input | 1 | Instruction writes `dec_dst` |
| dec_src_a | input | 6 | First source specifier |
| dec_src_a_vld | input | 1 | First source is used |
| dec_src_b | input | 6 | Second source specifier |
| dec_src_b_vld | input | 1 | Second source is used |
| wport_conflict | input | 1 | External write-port reservation refuses this cycle |
| dec_issue | output | 1 | Decode instruction issues this cycle |
| dec_stall | output | 1 | Decode instruction is held |
| fwd_sel_a | output | 3 | Forwarding select for the first source of the last issued instruction |
| fwd_sel_b | output | 3 | Forwarding select for the second source of the last issued instruction |

## Verification
Two things meet in one cycle here: the divider finishing and a waiting divide being accepted. The bench holds a second divide in decode behind a busy divider. The reference model then expects issue in exactly the 25th cycle, while the first divide is still in its final stage. A consumer of a divide result is also placed so that it issues in that final cycle and must then receive the divider's memory-stage select. Every cycle, the behavioural model recomputes issue, stall and both selects from the ages of the instructions in flight and compares them with the outputs.

// File: rtl/issue_guard_pkg.sv
package issue_guard_pkg;
    parameter int REG_IDX_W = 5;

    typedef struct packed {
        logic                 fp;
        logic [REG_IDX_W-1:0] idx;
    } reg_spec_t;

    typedef enum logic [2:0] {
        U_INT  = 3'd0,
        U_LOAD = 3'd1,
        U_FADD = 3'd2,
        U_FMUL = 3'd3,
        U_FDIV = 3'd4
    } unit_e;

    typedef enum logic [2:0] {
        FWD_NONE    = 3'd0,
        FWD_INT_MEM = 3'd1,
        FWD_ADD_MEM = 3'd2,
        FWD_MUL_MEM = 3'd3,
        FWD_DIV_MEM = 3'd4,
        FWD_MEM_WB  = 3'd5
    } fwd_e;

    typedef enum logic [1:0] {ORG_INT, ORG_ADD, ORG_MUL, ORG_DIV} origin_e;

    typedef struct packed {
        logic      v;
        logic      wr;
        logic      ld;
        reg_spec_t d;
    } slot_t;

    typedef struct packed {
        slot_t   s;
        origin_e org;
    } mem_slot_t;

    function automatic logic writes_to(slot_t s, reg_spec_t r);
        return s.v && s.wr && (s.d == r);
    endfunction
endpackage

// File: rtl/stage_tracker.sv
module stage_tracker
    import issue_guard_pkg::*;
#(
    parameter int ADD_DEPTH  = 4,
    parameter int MUL_DEPTH  = 7,
    parameter int DIV_CYCLES = 25,
    localparam int CNT_W     = $clog2(DIV_CYCLES + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  issue,
    input  unit_e                 unit,
    input  reg_spec_t             dst,
    input  logic                  dst_wr,
    output slot_t                 ex_q,
    output slot_t [ADD_DEPTH-1:0] add_q,
    output slot_t [MUL_DEPTH-1:0] mul_q,
    output slot_t                 div_q,
    output logic  [CNT_W-1:0]     div_cnt,
    output mem_slot_t             mem_q,
    output slot_t                 wb_q
);
    slot_t     new_s;
    mem_slot_t mem_d;
    logic      div_last;

    assign div_last = (div_cnt == CNT_W'(1));

    always_comb begin
        new_s.v  = 1'b1;
        new_s.wr = dst_wr;
        new_s.ld = (unit == U_LOAD);
        new_s.d  = dst;
    end

    // exactly one unit may hand a result to the memory stage per cycle
    always_comb begin
        mem_d = '0;
        if (ex_q.v) begin
            mem_d.s = ex_q;       mem_d.org = ORG_INT;
        end else if (add_q[ADD_DEPTH-1].v) begin
            mem_d.s = add_q[ADD_DEPTH-1]; mem_d.org = ORG_ADD;
        end else if (mul_q[MUL_DEPTH-1].v) begin
            mem_d.s = mul_q[MUL_DEPTH-1]; mem_d.org = ORG_MUL;
        end else if (div_last) begin
            mem_d.s = div_q;      mem_d.org = ORG_DIV;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ex_q    <= '0;
            add_q   <= '0;
            mul_q   <= '0;
            div_q   <= '0;
            div_cnt <= '0;
            mem_q   <= '0;
            wb_q    <= '0;
        end else begin
            ex_q     <= (issue && (unit == U_INT || unit == U_LOAD)) ? new_s : '0;
            add_q[0] <= (issue && unit == U_FADD) ? new_s : '0;
            mul_q[0] <= (issue && unit == U_FMUL) ? new_s : '0;
            for (int i = 1; i < ADD_DEPTH; i++) add_q[i] <= add_q[i-1];
            for (int i = 1; i < MUL_DEPTH; i++) mul_q[i] <= mul_q[i-1];
            if (issue && unit == U_FDIV) begin
                div_cnt <= CNT_W'(DIV_CYCLES);
                div_q   <= new_s;
            end else if (div_cnt != '0) begin
                div_cnt <= div_cnt - 1'b1;
                if (div_last) div_q <= '0;
            end
            mem_q <= mem_d;
            wb_q  <= mem_q.s;
        end
    end

    // R5: the external write-port reservation keeps completions apart
    assert_one_exit_R5: assert property (@(posedge clk) disable iff (rst)
        $countones({ex_q.v, add_q[ADD_DEPTH-1].v, mul_q[MUL_DEPTH-1].v, div_last}) <= 1);
endmodule

// File: rtl/hazard_detect.sv
module hazard_detect
    import issue_guard_pkg::*;
#(
    parameter int ADD_DEPTH  = 4,
    parameter int MUL_DEPTH  = 7,
    parameter int DIV_CYCLES = 25,
    localparam int CNT_W     = $clog2(DIV_CYCLES + 1)
) (
    input  unit_e                 unit,
    input  reg_spec_t             dst,
    input  logic                  dst_wr,
    input  reg_spec_t             src_a,
    input  logic                  src_a_vld,
    input  reg_spec_t             src_b,
    input  logic                  src_b_vld,
    input  slot_t                 ex_q,
    input  slot_t [ADD_DEPTH-1:0] add_q,
    input  slot_t [MUL_DEPTH-1:0] mul_q,
    input  slot_t                 div_q,
    input  logic  [CNT_W-1:0]     div_cnt,
    output logic                  struct_h,
    output logic                  raw_h,
    output logic                  waw_h
);
    function automatic logic src_hit(slot_t s, reg_spec_t a, logic av,
                                     reg_spec_t b, logic bv);
        return (av && writes_to(s, a)) || (bv && writes_to(s, b));
    endfunction

    logic div_long;
    assign div_long = (div_cnt > CNT_W'(1));

    always_comb begin
        raw_h = ex_q.ld && src_hit(ex_q, src_a, src_a_vld, src_b, src_b_vld);
        waw_h = 1'b0;
        for (int i = 0; i < ADD_DEPTH; i++) begin
            if (i < ADD_DEPTH - 1)
                raw_h = raw_h | src_hit(add_q[i], src_a, src_a_vld, src_b, src_b_vld);
            waw_h = waw_h | (dst_wr && writes_to(add_q[i], dst));
        end
        for (int i = 0; i < MUL_DEPTH; i++) begin
            if (i < MUL_DEPTH - 1)
                raw_h = raw_h | src_hit(mul_q[i], src_a, src_a_vld, src_b, src_b_vld);
            waw_h = waw_h | (dst_wr && writes_to(mul_q[i], dst));
        end
        if (div_long)
            raw_h = raw_h | src_hit(div_q, src_a, src_a_vld, src_b, src_b_vld);
        waw_h    = waw_h | (dst_wr && writes_to(div_q, dst));
        struct_h = (unit == U_FDIV) && div_long;
    end
endmodule

// File: rtl/fwd_select.sv
module fwd_select
    import issue_guard_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      issue,
    input  reg_spec_t src_a,
    input  logic      src_a_vld,
    input  reg_spec_t src_b,
    input  logic      src_b_vld,
    input  mem_slot_t mem_q,
    input  slot_t     wb_q,
    output fwd_e      sel_a,
    output fwd_e      sel_b
);
    localparam int N_OPS = 2;

    reg_spec_t src_q [N_OPS];
    logic      vld_q [N_OPS];
    fwd_e      sel   [N_OPS];

    function automatic fwd_e pick(reg_spec_t r, logic rv, mem_slot_t m, slot_t w);
        if (!rv) return FWD_NONE;
        if (writes_to(m.s, r) && !m.s.ld) begin
            case (m.org)
                ORG_INT: return FWD_INT_MEM;
                ORG_ADD: return FWD_ADD_MEM;
                ORG_MUL: return FWD_MUL_MEM;
                default: return FWD_DIV_MEM;
            endcase
        end
        if (writes_to(w, r)) return FWD_MEM_WB;
        return FWD_NONE;
    endfunction

    for (genvar g = 0; g < N_OPS; g++) begin : g_op
        always_ff @(posedge clk) begin
            if (rst) begin
                src_q[g] <= '0;
                vld_q[g] <= 1'b0;
            end else begin
                src_q[g] <= (g == 0) ? src_a : src_b;
                vld_q[g] <= issue && ((g == 0) ? src_a_vld : src_b_vld);
            end
        end
        assign sel[g] = pick(src_q[g], vld_q[g], mem_q, wb_q);
    end

    assign sel_a = sel[0];
    assign sel_b = sel[1];
endmodule

// File: rtl/fp_issue_guard.sv
module fp_issue_guard
    import issue_guard_pkg::*;
#(
    parameter int ADD_DEPTH  = 4,
    parameter int MUL_DEPTH  = 7,
    parameter int DIV_CYCLES = 25,
    localparam int SPEC_W    = REG_IDX_W + 1,
    localparam int CNT_W     = $clog2(DIV_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dec_valid,
    input  logic [2:0]        dec_unit,
    input  logic [SPEC_W-1:0] dec_dst,
    input  logic              dec_dst_wr,
    input  logic [SPEC_W-1:0] dec_src_a,
    input  logic              dec_src_a_vld,
    input  logic [SPEC_W-1:0] dec_src_b,
    input  logic              dec_src_b_vld,
    input  logic              wport_conflict,
    output logic              dec_issue,
    output logic              dec_stall,
    output logic [2:0]        fwd_sel_a,
    output logic [2:0]        fwd_sel_b
);
    unit_e                 unit;
    reg_spec_t             dst, sa, sb;
    slot_t                 ex_q, div_q, wb_q;
    slot_t [ADD_DEPTH-1:0] add_q;
    slot_t [MUL_DEPTH-1:0] mul_q;
    logic  [CNT_W-1:0]     div_cnt;
    mem_slot_t             mem_q;
    logic                  struct_h, raw_h, waw_h;
    fwd_e                  sel_a, sel_b;

    assign unit = unit_e'(dec_unit);
    assign dst  = dec_dst;
    assign sa   = dec_src_a;
    assign sb   = dec_src_b;

    assign dec_stall = dec_valid && (struct_h || raw_h || waw_h || wport_conflict);
    assign dec_issue = dec_valid && !dec_stall;
    assign fwd_sel_a = sel_a;
    assign fwd_sel_b = sel_b;

    stage_tracker #(.ADD_DEPTH(ADD_DEPTH), .MUL_DEPTH(MUL_DEPTH), .DIV_CYCLES(DIV_CYCLES)) u_track (
        .clk(clk), .rst(rst), .issue(dec_issue), .unit(unit), .dst(dst), .dst_wr(dec_dst_wr),
        .ex_q(ex_q), .add_q(add_q), .mul_q(mul_q), .div_q(div_q), .div_cnt(div_cnt),
        .mem_q(mem_q), .wb_q(wb_q)
    );

    hazard_detect #(.ADD_DEPTH(ADD_DEPTH), .MUL_DEPTH(MUL_DEPTH), .DIV_CYCLES(DIV_CYCLES)) u_haz (
        .unit(unit), .dst(dst), .dst_wr(dec_dst_wr),
        .src_a(sa), .src_a_vld(dec_src_a_vld), .src_b(sb), .src_b_vld(dec_src_b_vld),
        .ex_q(ex_q), .add_q(add_q), .mul_q(mul_q), .div_q(div_q), .div_cnt(div_cnt),
        .struct_h(struct_h), .raw_h(raw_h), .waw_h(waw_h)
    );

    fwd_select u_fwd (
        .clk(clk), .rst(rst), .issue(dec_issue),
        .src_a(sa), .src_a_vld(dec_src_a_vld), .src_b(sb), .src_b_vld(dec_src_b_vld),
        .mem_q(mem_q), .wb_q(wb_q), .sel_a(sel_a), .sel_b(sel_b)
    );

    // R2: back-to-back divides never both issue
    assert_div_busy_R2: assert property (@(posedge clk) disable iff (rst)
        (dec_issue && unit == U_FDIV) |=> !(dec_issue && unit == U_FDIV));

    // R3: a register just claimed by the adder cannot be claimed again next cycle
    assert_waw_block_R3: assert property (@(posedge clk) disable iff (rst)
        (dec_issue && unit == U_FADD && dec_dst_wr) |=>
        !(dec_issue && dec_dst_wr && dec_dst == $past(dec_dst)));

    // R4: a multiplier result is not consumed one cycle after issue
    assert_raw_block_R4: assert property (@(posedge clk) disable iff (rst)
        (dec_issue && unit == U_FMUL && dec_dst_wr) |=>
        !(dec_issue && ((dec_src_a_vld && dec_src_a == $past(dec_dst)) ||
                        (dec_src_b_vld && dec_src_b == $past(dec_dst)))));

    // R5: a refused write port always holds the instruction
    assert_port_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && wport_conflict) |-> (dec_stall && !dec_issue));

    // R6: the divider select only follows the divider's final cycle
    assert_div_fwd_R6: assert property (@(posedge clk) disable iff (rst)
        (fwd_sel_a == 3'd4) |-> $past(div_cnt == CNT_W'(1)));
endmodule

// File: tb/fp_issue_guard_bench.sv
`timescale 1ns/1ps
module fp_issue_guard_bench;
    localparam int UI = 0, UL = 1, UA = 2, UM = 3, UD = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dec_valid = 0, dec_dst_wr = 0, dec_src_a_vld = 0, dec_src_b_vld = 0;
    logic [2:0] dec_unit = 0;
    logic [5:0] dec_dst = 0, dec_src_a = 0, dec_src_b = 0;
    logic       wport_conflict = 0;
    logic       dec_issue, dec_stall;
    logic [2:0] fwd_sel_a, fwd_sel_b;

    always #4 clk = ~clk;

    fp_issue_guard u_fp_issue_guard (
        .clk(clk), .rst(rst), .dec_valid(dec_valid), .dec_unit(dec_unit),
        .dec_dst(dec_dst), .dec_dst_wr(dec_dst_wr),
        .dec_src_a(dec_src_a), .dec_src_a_vld(dec_src_a_vld),
        .dec_src_b(dec_src_b), .dec_src_b_vld(dec_src_b_vld),
        .wport_conflict(wport_conflict), .dec_issue(dec_issue), .dec_stall(dec_stall),
        .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b)
    );

    typedef struct { int unit; int dst; bit wr; int icyc; } rec_t;
    rec_t flight[$];
    bit   port_busy[int];
    int   cur = 0;
    int   n_checks = 0, n_fail = 0;
    bit   done = 0;
    bit   last_iss = 0, last_sav = 0, last_sbv = 0;
    int   last_sa = 0, last_sb = 0;

    function automatic int lat(int u);
        case (u)
            UA: return 4;
            UM: return 7;
            UD: return 25;
            default: return 1;
        endcase
    endfunction

    function automatic int F(int n); return 32 + n; endfunction

    task automatic check(bit ok, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", what, act, exp, cur);
        end
    endtask

    function automatic bit late_src(int s, bit sv);
        if (!sv) return 0;
        foreach (flight[i]) begin
            int k = cur - flight[i].icyc;
            int L = lat(flight[i].unit);
            if (flight[i].wr && flight[i].dst == s &&
                (k < L || (flight[i].unit == UL && k == L))) return 1;
        end
        return 0;
    endfunction

    function automatic bit waw_hit(int d, bit wr);
        if (!wr) return 0;
        foreach (flight[i]) begin
            int k = cur - flight[i].icyc;
            if (flight[i].unit >= UA && k <= lat(flight[i].unit) &&
                flight[i].wr && flight[i].dst == d) return 1;
        end
        return 0;
    endfunction

    function automatic bit div_busy();
        foreach (flight[i])
            if (flight[i].unit == UD && (cur - flight[i].icyc) < 25) return 1;
        return 0;
    endfunction

    function automatic int exp_fwd(int s, bit sv, output bit both);
        int mem_code = 0;
        bit wbm = 0;
        both = 0;
        if (!sv) return 0;
        foreach (flight[i]) begin
            int k = cur - flight[i].icyc;
            int L = lat(flight[i].unit);
            if (flight[i].wr && flight[i].dst == s) begin
                if (k == L + 1 && flight[i].unit != UL)
                    mem_code = (flight[i].unit == UI) ? 1 : flight[i].unit;
                if (k == L + 2) wbm = 1;
            end
        end
        both = (mem_code != 0) && wbm;
        if (mem_code != 0) return mem_code;
        if (wbm) return 5;
        return 0;
    endfunction

    task automatic prune();
        for (int i = flight.size() - 1; i >= 0; i--)
            if (cur - flight[i].icyc > lat(flight[i].unit) + 2) flight.delete(i);
    endtask

    // one decode cycle; returns whether the model expects issue
    task automatic step(bit v, int u, int d, bit wr, int sa, bit sav, int sb, bit sbv,
                        bit extra, string note, output bit issued);
        bit st, rw, ww, wp, exp_iss, both_a, both_b;
        int fa, fb;
        string tag;
        @(negedge clk);
        prune();
        wp = v && (port_busy.exists(cur + lat(u) + 1) || extra);
        dec_valid = v; dec_unit = 3'(u); dec_dst = 6'(d); dec_dst_wr = wr;
        dec_src_a = 6'(sa); dec_src_a_vld = sav; dec_src_b = 6'(sb); dec_src_b_vld = sbv;
        wport_conflict = wp;
        #1;
        st = v && (u == UD) && div_busy();
        rw = v && (late_src(sa, sav) || late_src(sb, sbv));
        ww = v && waw_hit(d, wr);
        exp_iss = v && !st && !rw && !ww && !wp;
        if (st) tag = "R2"; else if (ww) tag = "R3"; else if (rw) tag = "R4";
        else if (wp) tag = "R5"; else tag = "R1";
        check({dec_issue, dec_stall} == {exp_iss, v && !exp_iss},
              {note, " ", tag, " issue/stall"}, {dec_issue, dec_stall}, {exp_iss, v && !exp_iss});
        fa = exp_fwd(last_sa, last_iss && last_sav, both_a);
        fb = exp_fwd(last_sb, last_iss && last_sbv, both_b);
        check(fwd_sel_a == 3'(fa), both_a ? "R7 fwd_sel_a" : "R6 fwd_sel_a", fwd_sel_a, fa);
        check(fwd_sel_b == 3'(fb), both_b ? "R7 fwd_sel_b" : "R6 fwd_sel_b", fwd_sel_b, fb);
        if (exp_iss) begin
            rec_t r;
            r.unit = u; r.dst = d; r.wr = wr; r.icyc = cur;
            flight.push_back(r);
            port_busy[cur + lat(u) + 1] = 1;
        end
        last_iss = exp_iss; last_sa = sa; last_sav = sav; last_sb = sb; last_sbv = sbv;
        issued = exp_iss;
        @(posedge clk);
        cur++;
    endtask

    task automatic send(int u, int d, bit wr, int sa, bit sav, int sb, bit sbv,
                        string note, bit ext_rand = 0);
        bit iss;
        for (int n = 0; n < 80; n++) begin
            step(1, u, d, wr, sa, sav, sb, sbv, ext_rand && ($urandom_range(9) == 0), note, iss);
            if (iss) return;
        end
        check(0, {note, " R1 instruction never issued"}, 0, 1);
    endtask

    task automatic idle(int n);
        bit iss;
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 0, "idle", iss);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; dec_valid = 0; wport_conflict = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        flight.delete(); port_busy.delete(); last_iss = 0;
        #1;
        check({dec_issue, dec_stall} == 2'b00, "R9 reset issue/stall", {dec_issue, dec_stall}, 0);
        check(fwd_sel_a == 0 && fwd_sel_b == 0, "R9 reset fwd", {fwd_sel_a, fwd_sel_b}, 0);
    endtask

    initial begin
        do_reset();
        // R1: pipelined units accept every cycle
        send(UA, F(1), 1, F(20), 1, F(21), 1, "R1");
        send(UA, F(2), 1, F(20), 1, 0, 0, "R1");
        send(UM, F(3), 1, F(22), 1, 0, 0, "R1");
        send(UM, F(4), 1, F(22), 1, 0, 0, "R1");
        idle(12);
        // R4/R6: each producer class then an immediate consumer
        send(UI, 5, 1, 6, 1, 0, 0, "R4");
        send(UI, 7, 1, 5, 1, 0, 0, "R6");
        send(UA, F(6), 1, F(20), 1, 0, 0, "R4");
        send(UA, F(7), 1, F(6), 1, 0, 0, "R6");
        idle(8);
        send(UM, F(8), 1, F(20), 1, 0, 0, "R4");
        send(UI, 9, 1, 0, 0, F(8), 1, "R6");
        idle(8);
        send(UL, F(9), 1, 3, 1, 0, 0, "R4");
        send(UA, F(10), 1, F(9), 1, 0, 0, "R6");
        idle(8);
        // R2/R6: divide, dependent consumer, then a queued divide
        send(UD, F(11), 1, F(1), 1, F(2), 1, "R2");
        send(UA, F(12), 1, F(11), 1, 0, 0, "R6");
        idle(3);
        send(UD, F(13), 1, F(1), 1, 0, 0, "R2");
        send(UD, F(14), 1, F(1), 1, 0, 0, "R2");
        send(UA, F(15), 1, F(14), 1, 0, 0, "R2");
        idle(30);
        // R3: write-after-write against multiplier and divider
        send(UM, F(16), 1, F(1), 1, 0, 0, "R3");
        send(UA, F(16), 1, F(2), 1, 0, 0, "R3");
        send(UD, F(17), 1, F(1), 1, 0, 0, "R3");
        send(UI, F(17), 1, 1, 1, 0, 0, "R3");
        idle(30);
        // R7: two integer writers of one register, then a reader
        send(UI, 12, 1, 1, 1, 0, 0, "R7");
        send(UI, 12, 1, 2, 1, 0, 0, "R7");
        send(UI, 13, 1, 12, 1, 12, 1, "R7");
        idle(4);
        // R8: same index in the other file does not match
        send(UM, F(3), 1, F(1), 1, 0, 0, "R8");
        send(UA, 3, 1, 3, 1, 4, 1, "R8");
        send(UA, F(18), 1, F(3), 1, 0, 0, "R8");
        idle(10);
        // R5: multiply then add that would reach memory together
        send(UM, F(20), 1, F(1), 1, 0, 0, "R5");
        idle(2);
        send(UA, F(21), 1, F(2), 1, 0, 0, "R5");
        idle(12);
        // R9: reset with a divide in flight
        send(UD, F(22), 1, F(1), 1, 0, 0, "R9");
        idle(3);
        do_reset();
        send(UD, F(22), 1, F(1), 1, 0, 0, "R9");
        idle(30);
        // mixed random stream over a small register set
        for (int n = 0; n < 300; n++) begin
            int u = $urandom_range(9);
            u = (u < 3) ? UI : (u < 4) ? UL : (u < 6) ? UA : (u < 8) ? UM : (u < 9) ? UD : UI;
            if ($urandom_range(4) == 0) idle(1);
            send(u, $urandom_range(1) * 32 + $urandom_range(1, 4), $urandom_range(5) != 0,
                 $urandom_range(1) * 32 + $urandom_range(1, 4), $urandom_range(3) != 0,
                 $urandom_range(1) * 32 + $urandom_range(1, 4), $urandom_range(1),
                 "rand", 1);
        end
        idle(30);
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        end
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog expired R1 actual=0 expected=1");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        end
        $finish;
    end
endmodule